// File: doc/BRIEF.md
# Transceiver Management Memory Target

This block is the serial management target of a pluggable optical transceiver. It listens on a two-wire bus (clock plus open-drain data), oversampled by the core clock. It answers two device addresses. The identification page is read-only. The diagnostics page holds real-time measurements, a status/control byte and a region the host may write.

A host selects a byte with a write of the word address. It then reads one or more bytes through a repeated start, or writes data bytes straight after the word address. The word pointer steps by one after every data byte and wraps within the 256-byte page.

The status byte is built at the moment it is fetched from the live transmitter-disable pin, fault and loss-of-signal levels, and a measurement-valid input. The software transmit-disable bit in that byte drives an output to the transmit control logic. The real-time values are latched as a group when a read's device address is accepted, so the two bytes of one value always belong together.

Top module: `xcvr_mgmt_target`

## Requirements
- R1: Only 7-bit device addresses 0x50 (byte A0h, identification page) and 0x51 (byte A2h, diagnostics page) are acknowledged. Any other address, including 0x58 (byte B0h), is never acknowledged, and SDA stays released until the next start.
- R2: Identification byte `a` reads `a XOR ID_SALT` (default A5h). Writes to that page are acknowledged and change nothing.
- R3: A write of a word address followed by a repeated-start read returns the byte at that address. Further bytes of the same read come from the next addresses, wrapping from 255 to 0.
- R4: Diagnostics bytes 128 to 247 hold what the host writes and read back as 0 after reset.
- R5: Bit 6 of diagnostics byte 110 is read/write. Output `soft_tx_dis` follows it, and it resets to 0.
- R6: A read of diagnostics byte 110 returns bit7 = `tx_dis_pin`, bit6 = software disable, bits 5..3 = 0, bit2 = `tx_fault`, bit1 = `rx_los` and bit0 = NOT `meas_valid`, as those inputs stand when the byte is fetched.
- R7: A write to diagnostics byte 127 is acknowledged and has no effect. The byte keeps reading `127 XOR DIAG_SALT`.
- R8: All other diagnostics bytes read `a XOR DIAG_SALT` (default 5Ah). Writes to them are acknowledged and discarded.
- R9: Real-time value k (k = 0..4, from `rt_values[16k+15:16k]`) sits at bytes 96+2k (high byte) and 97+2k (low byte). It is sampled when a read address is acknowledged and does not change during that read.
- R10: Every address, word address and data byte sent to a matching device is acknowledged. A master NACK ends a read. A stop releases SDA and returns the target to idle.
- R11: A start anywhere, even inside a byte, abandons the current transfer and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired) |
| sda_oe | output | 1 | 1 pulls SDA low |
| tx_dis_pin | input | 1 | Hardware transmit-disable level |
| tx_fault | input | 1 | Transmitter fault level |
| rx_los | input | 1 | Receiver loss-of-signal level |
| meas_valid | input | 1 | Real-time values valid |
| rt_values | input | NVAL*16 | Real-time measurements, value 0 in the low bits |
| soft_tx_dis | output | 1 | Software transmit-disable bit |

## Verification
Bus inputs pass a two-stage synchronizer and an edge detector, so the target reacts three to four core cycles after an SCL edge. The bench holds each SCL phase for at least four core cycles and samples SDA in the middle of the high phase, well after the target has settled. Writes land one cycle after the acknowledge is driven. `soft_tx_dis` and the written bytes are therefore checked only after the stop, and always through a later read or at the output pin. Status and real-time bytes are compared with values the bench computes from the inputs it held steady while the byte was fetched.

// File: rtl/xmt_pkg.sv
// Shared types for the transceiver management target.
// Assumes the byte-wide two-wire protocol with 8 data bits plus one acknowledge bit.
package xmt_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_AACK, S_WORD, S_WACK, S_WDAT, S_RD, S_RACK
    } link_st_t;

    // bit positions inside the status/control byte (decoded by the host)
    localparam int ST_PIN   = 7;
    localparam int ST_SOFT  = 6;
    localparam int ST_FAULT = 2;
    localparam int ST_LOS   = 1;
    localparam int ST_NRDY  = 0;
endpackage

// File: rtl/xmt_link.sv
// Bit-level two-wire target: synchronizes SCL/SDA to clk, detects start/stop,
// matches two device addresses, shifts bytes and drives acknowledges/read data.
// Assumes each SCL phase lasts at least four clk cycles. Emits one-cycle strobes
// to the memory map; rd_data must be valid combinationally from the current pointer.
module xmt_link
    import xmt_pkg::*;
#(
    parameter logic [6:0] ID_DEV   = 7'h50,
    parameter logic [6:0] DIAG_DEV = 7'h51
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       page_o,
    output logic       ptr_load,
    output logic       wr_stb,
    output logic       rd_adv,
    output logic       snap,
    output logic [7:0] byte_o
);
    logic [2:0] scl_q, sda_q;
    logic       scl_s, scl_p, sda_s, sda_p;
    logic       scl_r, scl_f, start_ev, stop_ev;
    link_st_t   state;
    logic [7:0] shreg, txreg;
    logic [3:0] bitn;
    logic       sda_lo, rw, dev_hit;

    // two-flop synchronizer plus one history stage per bus line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    // edge and bus-condition decode
    always_comb begin
        scl_s    = scl_q[1];
        scl_p    = scl_q[2];
        sda_s    = sda_q[1];
        sda_p    = sda_q[2];
        scl_r    = scl_s & ~scl_p;
        scl_f    = ~scl_s & scl_p;
        start_ev = scl_s & scl_p & sda_p & ~sda_s;
        stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
        dev_hit  = (shreg[7:1] == ID_DEV) || (shreg[7:1] == DIAG_DEV);
    end

    // protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; shreg <= '0; txreg <= '0; bitn <= '0;
            sda_lo <= 1'b0; rw <= 1'b0; page_o <= 1'b0;
            ptr_load <= 1'b0; wr_stb <= 1'b0; rd_adv <= 1'b0; snap <= 1'b0;
        end else begin
            ptr_load <= 1'b0; wr_stb <= 1'b0; rd_adv <= 1'b0; snap <= 1'b0;
            if (stop_ev) begin
                state  <= S_IDLE;
                sda_lo <= 1'b0;
            end else if (start_ev) begin
                state  <= S_ADDR;
                bitn   <= '0;
                sda_lo <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_WORD, S_WDAT: begin
                        if (scl_r && bitn != 4'd8) begin
                            shreg <= {shreg[6:0], sda_s};
                            bitn  <= bitn + 4'd1;
                        end else if (scl_f && bitn == 4'd8) begin
                            bitn <= '0;
                            if (state == S_ADDR) begin
                                if (dev_hit) begin
                                    sda_lo <= 1'b1;
                                    rw     <= shreg[0];
                                    page_o <= (shreg[7:1] == DIAG_DEV);
                                    snap   <= shreg[0];
                                    state  <= S_AACK;
                                end else begin
                                    state <= S_IDLE;
                                end
                            end else begin
                                ptr_load <= (state == S_WORD);
                                wr_stb   <= (state == S_WDAT);
                                sda_lo   <= 1'b1;
                                state    <= S_WACK;
                            end
                        end
                    end
                    S_AACK: begin
                        if (scl_f) begin
                            if (rw) begin
                                txreg <= rd_data; sda_lo <= ~rd_data[7];
                                bitn <= 4'd1; rd_adv <= 1'b1; state <= S_RD;
                            end else begin
                                sda_lo <= 1'b0; state <= S_WORD;
                            end
                        end
                    end
                    S_WACK: begin
                        if (scl_f) begin
                            sda_lo <= 1'b0;
                            state  <= S_WDAT;
                        end
                    end
                    S_RD: begin
                        if (scl_f) begin
                            if (bitn == 4'd8) begin
                                sda_lo <= 1'b0;
                                state  <= S_RACK;
                            end else begin
                                sda_lo <= ~txreg[6];
                                txreg  <= {txreg[6:0], 1'b0};
                                bitn   <= bitn + 4'd1;
                            end
                        end
                    end
                    S_RACK: begin
                        if (scl_r && sda_s) begin
                            state <= S_IDLE;
                        end else if (scl_f) begin
                            txreg <= rd_data; sda_lo <= ~rd_data[7];
                            bitn <= 4'd1; rd_adv <= 1'b1; state <= S_RD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = sda_lo;
    assign byte_o = shreg;

    // SDA is only ever pulled low in response to an SCL fall
    assert_pull_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_lo) |-> !$past(scl_s));
    // a stop always releases the bus and parks the sequencer
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!sda_lo && state == S_IDLE));
    // a start restarts the address phase from bit zero
    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == S_ADDR && bitn == 4'd0));
    // an unaddressed target never pulls SDA
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start_ev) |=> !sda_lo);
endmodule

// File: rtl/xmt_map.sv
// Two-page byte map: word pointer, writable region, software-disable bit,
// real-time snapshot and the read multiplexer with live status merge.
// Assumes strobes from xmt_link are one-cycle pulses, never two at once.
module xmt_map
    import xmt_pkg::*;
#(
    parameter logic [7:0] ID_SALT   = 8'hA5,
    parameter logic [7:0] DIAG_SALT = 8'h5A,
    parameter int         NVAL      = 5,
    parameter int         RT_BASE   = 96,
    parameter int         STAT_ADDR = 110,
    parameter int         WR_LO     = 128,
    parameter int         WR_HI     = 247
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               page,
    input  logic               ptr_load,
    input  logic               wr_stb,
    input  logic               rd_adv,
    input  logic               snap,
    input  logic [7:0]         wdata,
    input  logic               tx_dis_pin,
    input  logic               tx_fault,
    input  logic               rx_los,
    input  logic               meas_valid,
    input  logic [NVAL*16-1:0] rt_values,
    output logic [7:0]         rd_data,
    output logic               soft_tx_dis
);
    localparam int         WR_N   = WR_HI - WR_LO + 1;
    localparam int         AW     = $clog2(WR_N);
    localparam int         SW     = (NVAL > 1) ? $clog2(NVAL) : 1;
    localparam logic [7:0] RT_LO8 = 8'(RT_BASE);
    localparam logic [7:0] RT_HI8 = 8'(RT_BASE + 2 * NVAL - 1);
    localparam logic [7:0] ST8    = 8'(STAT_ADDR);
    localparam logic [7:0] WL8    = 8'(WR_LO);
    localparam logic [7:0] WH8    = 8'(WR_HI);

    logic [7:0]    ptr;
    logic [7:0]    ram [WR_N];
    logic [15:0]   snapv [NVAL];
    logic          in_wr, in_rt;
    logic [AW-1:0] widx;
    logic [7:0]    roff;
    logic [SW-1:0] sidx;
    logic [7:0]    status;

    // address region decode
    always_comb begin
        in_wr  = (ptr >= WL8) && (ptr <= WH8);
        in_rt  = (ptr >= RT_LO8) && (ptr <= RT_HI8);
        widx   = AW'(ptr - WL8);
        roff   = ptr - RT_LO8;
        sidx   = SW'(roff >> 1);
        status = '0;
        status[ST_PIN]   = tx_dis_pin;
        status[ST_SOFT]  = soft_tx_dis;
        status[ST_FAULT] = tx_fault;
        status[ST_LOS]   = rx_los;
        status[ST_NRDY]  = ~meas_valid;
    end

    // word pointer: load on word address, step after every data byte
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr <= '0;
        else if (ptr_load)         ptr <= wdata;
        else if (wr_stb || rd_adv) ptr <= ptr + 8'd1;
    end

    // host-writable region and software-disable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WR_N; i++) ram[i] <= '0;
            soft_tx_dis <= 1'b0;
        end else if (wr_stb && page) begin
            if (in_wr)      ram[widx]   <= wdata;
            if (ptr == ST8) soft_tx_dis <= wdata[ST_SOFT];
        end
    end

    // one holding register per real-time value, loaded together on a read start
    for (genvar k = 0; k < NVAL; k++) begin : g_snap
        always_ff @(posedge clk) begin
            if (!rst_n)    snapv[k] <= '0;
            else if (snap) snapv[k] <= rt_values[16*k +: 16];
        end
    end

    // read multiplexer
    always_comb begin
        if (!page)          rd_data = ptr ^ ID_SALT;
        else if (in_rt)     rd_data = roff[0] ? snapv[sidx][7:0] : snapv[sidx][15:8];
        else if (ptr == ST8) rd_data = status;
        else if (in_wr)     rd_data = ram[widx];
        else                rd_data = ptr ^ DIAG_SALT;
    end

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ptr_load, wr_stb, rd_adv}));
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_adv) |=> (ptr == $past(ptr) + 8'd1));
    assert_soft_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && page && ptr == ST8) |=> $stable(soft_tx_dis));
    assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(snapv[0]));
endmodule

// File: rtl/xcvr_mgmt_target.sv
// Top of the transceiver management target: two-wire link plus byte map.
// Assumes an external open-drain pad: sda_oe=1 pulls the line low.
module xcvr_mgmt_target #(
    parameter logic [6:0] ID_DEV    = 7'h50,
    parameter logic [6:0] DIAG_DEV  = 7'h51,
    parameter logic [7:0] ID_SALT   = 8'hA5,
    parameter logic [7:0] DIAG_SALT = 8'h5A,
    parameter int         NVAL      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic               tx_dis_pin,
    input  logic               tx_fault,
    input  logic               rx_los,
    input  logic               meas_valid,
    input  logic [NVAL*16-1:0] rt_values,
    output logic               soft_tx_dis
);
    logic       page, ptr_load, wr_stb, rd_adv, snap;
    logic [7:0] byte_v, rd_data;

    xmt_link #(.ID_DEV(ID_DEV), .DIAG_DEV(DIAG_DEV)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .rd_data(rd_data), .sda_oe(sda_oe), .page_o(page),
        .ptr_load(ptr_load), .wr_stb(wr_stb), .rd_adv(rd_adv),
        .snap(snap), .byte_o(byte_v)
    );

    xmt_map #(.ID_SALT(ID_SALT), .DIAG_SALT(DIAG_SALT), .NVAL(NVAL)) u_map (
        .clk(clk), .rst_n(rst_n), .page(page), .ptr_load(ptr_load),
        .wr_stb(wr_stb), .rd_adv(rd_adv), .snap(snap), .wdata(byte_v),
        .tx_dis_pin(tx_dis_pin), .tx_fault(tx_fault), .rx_los(rx_los),
        .meas_valid(meas_valid), .rt_values(rt_values),
        .rd_data(rd_data), .soft_tx_dis(soft_tx_dis)
    );
endmodule

// File: tb/test_xcvr_mgmt_target.sv
module test_xcvr_mgmt_target;
    localparam int Q    = 4;
    localparam int NVAL = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, soft_tx_dis;
    logic tx_dis_pin = 1'b0, tx_fault = 1'b0, rx_los = 1'b0, meas_valid = 1'b1;
    logic [NVAL*16-1:0] rt_values = '0, rt_exp;
    wire  sda_bus = sda_m & ~sda_oe;

    int tests = 0, fails = 0, cycles = 0;
    logic [7:0] buf_q [16];
    logic [7:0] exp_q [16];
    logic [7:0] m_ram [256];
    logic       m_soft = 1'b0;

    always #2 clk = ~clk;

    xcvr_mgmt_target i_xcvr_mgmt_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .tx_dis_pin(tx_dis_pin), .tx_fault(tx_fault), .rx_los(rx_los),
        .meas_valid(meas_valid), .rt_values(rt_values), .soft_tx_dis(soft_tx_dis)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        waitq(Q); sda_m = b; waitq(Q); scl_m = 1'b1; waitq(2 * Q); scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; waitq(2 * Q); scl_m = 1'b1; waitq(Q); b = sda_bus; waitq(Q); scl_m = 1'b0;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(2 * Q); sda_m = 1'b0; waitq(2 * Q);
        scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        waitq(Q); sda_m = 1'b0; waitq(Q); scl_m = 1'b1; waitq(2 * Q); sda_m = 1'b1; waitq(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
        bit_out(~mack);
    endtask

    // model of the map, derived from the requirements
    function automatic logic [7:0] exp_byte(input logic pg, input int a);
        if (!pg) return 8'(a) ^ 8'hA5;                              // R2
        if (a >= 96 && a < 96 + 2 * NVAL) begin                     // R9
            logic [15:0] v = rt_exp[16 * ((a - 96) / 2) +: 16];
            return (a % 2 == 0) ? v[15:8] : v[7:0];
        end
        if (a == 110) return {tx_dis_pin, m_soft, 3'b000, tx_fault, rx_los, ~meas_valid}; // R6
        if (a >= 128 && a <= 247) return m_ram[a];                  // R4
        return 8'(a) ^ 8'h5A;                                       // R7, R8
    endfunction

    // write transaction: dev, word address, n bytes from buf_q; checks every ack (R10)
    task automatic wr_txn(input logic pg, input logic [7:0] wa, input int n);
        logic ack;
        i2c_start();
        send_byte({pg ? 7'h51 : 7'h50, 1'b0}, ack); check("R10 addr ack", ack, 1);
        send_byte(wa, ack);                          check("R10 word ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(buf_q[i], ack);                check("R10 data ack", ack, 1);
            if (pg) begin
                int a = (wa + i) % 256;
                if (a >= 128 && a <= 247) m_ram[a] = buf_q[i];
                if (a == 110) m_soft = buf_q[i][6];
            end
        end
        i2c_stop();
    endtask

    // random read of n bytes into buf_q; optional mutation of rt inputs after first byte
    task automatic rd_txn(input logic pg, input logic [7:0] wa, input int n, input bit mutate);
        logic ack;
        i2c_start();
        send_byte({pg ? 7'h51 : 7'h50, 1'b0}, ack); check("R3 addr ack", ack, 1);
        send_byte(wa, ack);                          check("R3 word ack", ack, 1);
        i2c_start();
        send_byte({pg ? 7'h51 : 7'h50, 1'b1}, ack); check("R3 read addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(buf_q[i], i != n - 1);
            if (mutate && i == 0) rt_values = {$urandom, $urandom, $urandom};
        end
        i2c_stop();
    endtask

    task automatic rd_check(input string req, input logic pg, input logic [7:0] wa, input int n,
                            input bit mutate);
        rt_exp = rt_values;
        for (int i = 0; i < n; i++) exp_q[i] = exp_byte(pg, (wa + i) % 256);
        rd_txn(pg, wa, n, mutate);
        for (int i = 0; i < n; i++) check(req, buf_q[i], exp_q[i]);
    endtask

    // watchdog: a hung run is one failed check
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                tests++; fails++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic ack;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) m_ram[i] = '0;
        rt_values = {$urandom, $urandom, $urandom};
        waitq(10); rst_n = 1'b1; waitq(4);
        check("R10 reset sda released", sda_oe, 0);
        check("R5 reset soft disable", soft_tx_dis, 0);

        // R1: reserved and random foreign addresses are not acknowledged
        i2c_start(); send_byte(8'hB0, ack); i2c_stop(); check("R1 B0h write nack", ack, 0);
        i2c_start(); send_byte(8'hB1, ack); i2c_stop(); check("R1 B1h read nack", ack, 0);
        for (int k = 0; k < 5; k++) begin
            logic [6:0] d;
            do d = 7'($urandom); while (d == 7'h50 || d == 7'h51);
            i2c_start(); send_byte({d, 1'($urandom)}, ack);
            check("R1 foreign quiet", sda_oe, 0);
            i2c_stop(); check("R1 foreign nack", ack, 0);
        end

        // R2: identification reads and discarded writes
        for (int i = 0; i < 4; i++) buf_q[i] = 8'($urandom);
        wr_txn(1'b0, 8'h14, 4);
        rd_check("R2 id page", 1'b0, 8'h12, 8, 0);

        // R3: sequential read across the wrap in both pages
        rd_check("R3 id wrap", 1'b0, 8'hFD, 5, 0);
        rd_check("R3 diag wrap", 1'b1, 8'hFE, 4, 0);

        // R4: random writes to the host region, read back with neighbours
        for (int k = 0; k < 5; k++) begin
            int n = 1 + int'($urandom % 6);
            logic [7:0] wa = 8'(128 + $urandom % 113);
            for (int i = 0; i < n; i++) buf_q[i] = 8'($urandom);
            wr_txn(1'b1, wa, n);
            rd_check("R4 host region", 1'b1, wa - 8'd1, n + 2, 0);
        end
        // R4/R8: write across the top of the host region
        for (int i = 0; i < 3; i++) buf_q[i] = 8'hC3 + 8'(i);
        wr_txn(1'b1, 8'd246, 3);
        rd_check("R4 R8 region edge", 1'b1, 8'd245, 5, 0);

        // R5: software disable bit through byte 110
        buf_q[0] = 8'h40; wr_txn(1'b1, 8'd110, 1);
        check("R5 soft set", soft_tx_dis, 1);
        rd_check("R5 soft readback", 1'b1, 8'd110, 1, 0);
        buf_q[0] = 8'hBF; wr_txn(1'b1, 8'd110, 1);
        check("R5 soft clear", soft_tx_dis, 0);

        // R6: live status merge under several pin patterns
        for (int k = 0; k < 6; k++) begin
            {tx_dis_pin, tx_fault, rx_los, meas_valid} = 4'($urandom);
            rd_check("R6 status byte", 1'b1, 8'd110, 1, 0);
        end
        meas_valid = 1'b1;

        // R7: byte 127 takes a write and keeps nothing
        buf_q[0] = 8'hFF; buf_q[1] = 8'h00; buf_q[2] = 8'h77;
        wr_txn(1'b1, 8'd126, 3);
        rd_check("R7 null byte", 1'b1, 8'd126, 3, 0);

        // R8: read-only thresholds ignore writes
        for (int i = 0; i < 4; i++) buf_q[i] = 8'($urandom);
        wr_txn(1'b1, 8'd0, 4);
        rd_check("R8 read only", 1'b1, 8'd0, 4, 0);

        // R9: real-time values are frozen for the whole read
        rd_check("R9 snapshot held", 1'b1, 8'd96, 2 * NVAL, 1);
        rd_check("R9 new snapshot", 1'b1, 8'd96, 2 * NVAL, 0);

        // R11: start inside a byte abandons it
        i2c_start(); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        rd_check("R11 restart mid byte", 1'b1, 8'd130, 2, 0);

        // R10: after a NACKed read and stop the bus is released
        check("R10 released after stop", sda_oe, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule